// File: doc/BRIEF.md
# DDS Control Word Register File

This block sits between a serial-to-parallel front end and a direct digital synthesis core. Every 16-bit word that arrives with a one-cycle write strobe is decoded by its top two bits. The word then updates one of the following: the control register, one of two 28-bit tuning words, or one of two 12-bit phase offsets. The stored values and the decoded control flags go straight out to the waveform core. The block also presents the tuning word and phase offset that the control register currently selects.

A tuning word is wider than a data word, so it is written in 14-bit halves. Split mode is active while the sequential-load flag is clear: each write replaces the half chosen by a control flag and leaves the other half alone. Paired mode is active while the sequential-load flag is set: a first write holds its low half in a shadow register, and a second write to the same tuning word supplies the high half and loads all 28 bits in one cycle. The core therefore never sees a half-updated word. A flag reports that the high half is expected next.

Top module: `dds_cw_regfile`

## Requirements
- R1: While rst_ni is low, every register, both tuning words, both phase offsets, all flags and the pending flag are zero.
- R2: A word with bits 15:14 = 00 loads the control register one cycle after the strobe. The flags map as follows: bit 13 paired mode, bit 12 high-half select, bit 11 tuning select, bit 10 phase select, bit 8 core reset, bit 7 clock hold, bit 6 DAC power-down, bit 5 MSB output, bit 3 MSB halving, bit 1 triangle (1) / sine (0).
- R3: A word with bits 15:14 = 11 writes bits 11:0 into phase offset 0 when bit 13 = 0, or into phase offset 1 when bit 13 = 1. Bit 12 is ignored.
- R4: In split mode, a word with bits 15:14 = 01 (tuning 0) or 10 (tuning 1) writes bits 13:0 into bits 13:0 of that tuning word when high-half select is 0, or into bits 27:14 when it is 1. The other half keeps its value.
- R5: In paired mode, a first tuning write leaves both tuning words unchanged and sets the pending flag. A second write to the same tuning word loads {second payload, first payload} and clears the pending flag.
- R6: A control register write clears the pending flag, so the next tuning write is taken as a low half again.
- R7: In paired mode, a tuning write to the other tuning word while a high half is pending discards the held low half. That word starts a new pair for its own target, and neither tuning word changes.
- R8: freq_o equals tuning 1 when tuning select is 1 and tuning 0 otherwise. phase_o follows phase select in the same way.
- R9: With wr_i low, no register changes, whatever word_i holds.
- R10: A phase write does not change the pending flag or the held low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle strobe marking a valid word |
| word_i | input | 16 | Control word |
| freq0_o | output | 28 | Tuning word 0 |
| freq1_o | output | 28 | Tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| freq_o | output | 28 | Selected tuning word |
| phase_o | output | 12 | Selected phase offset |
| seq_en_o | output | 1 | Paired mode active |
| hi_half_o | output | 1 | Split-mode high-half select |
| freq_sel_o | output | 1 | Tuning select |
| phase_sel_o | output | 1 | Phase select |
| core_rst_o | output | 1 | Core reset request |
| clk_hold_o | output | 1 | Clock hold |
| dac_off_o | output | 1 | DAC path power-down |
| msb_out_o | output | 1 | Route accumulator MSB to output |
| msb_div_o | output | 1 | MSB halving control |
| tri_mode_o | output | 1 | Triangle (1) or sine (0) |
| hi_pending_o | output | 1 | High half of a pair expected next |

## Verification
The hardest states to reach are the ones where a high half is pending and something other than its matching high half arrives: a write to the other tuning word, a control write, or a phase write. The stimulus table opens each pair on one target and then interrupts it with each of these words in turn. After each interruption it checks that both tuning words are untouched and that the pending flag has the value required. It then closes the pair and compares the assembled 28-bit value, which shows which low half survived.

// File: rtl/dds_cw_pkg.sv
package dds_cw_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = 14;
  localparam int FREQ_W  = 2 * HALF_W;
  localparam int PHASE_W = 12;
  localparam int NBANK   = 2;

  // bit positions inside a control word
  localparam int B_SEQ = 13, B_HI = 12, B_FSEL = 11, B_PSEL = 10, B_CRST = 8;
  localparam int B_HOLD = 7, B_DAC = 6, B_MSBO = 5, B_MSBD = 3, B_TRI = 1;
  localparam int B_PBANK = 13;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'b00,
    TGT_F0   = 2'b01,
    TGT_F1   = 2'b10,
    TGT_PH   = 2'b11
  } tgt_e;

  typedef struct packed {
    logic seq_en;
    logic hi_half;
    logic fsel;
    logic psel;
    logic core_rst;
    logic clk_hold;
    logic dac_off;
    logic msb_out;
    logic msb_div;
    logic tri_sel;
  } ctrl_t;
endpackage

// File: rtl/dds_cw_decode.sv
module dds_cw_decode
  import dds_cw_pkg::*;
(
  input  logic                 wr_i,
  input  logic [WORD_W-1:0]    word_i,
  output logic                 ctrl_we_o,
  output ctrl_t                ctrl_o,
  output logic [NBANK-1:0]     freq_we_o,
  output logic [NBANK-1:0]     ph_we_o,
  output logic [HALF_W-1:0]    hdata_o,
  output logic [PHASE_W-1:0]   pdata_o
);
  tgt_e tgt;
  logic unused_bits;

  assign tgt         = tgt_e'(word_i[WORD_W-1 -: 2]);
  assign ctrl_we_o   = wr_i && (tgt == TGT_CTRL);
  assign freq_we_o[0] = wr_i && (tgt == TGT_F0);
  assign freq_we_o[1] = wr_i && (tgt == TGT_F1);
  assign hdata_o     = word_i[HALF_W-1:0];
  assign pdata_o     = word_i[PHASE_W-1:0];

  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_phwe
      assign ph_we_o[k] = wr_i && (tgt == TGT_PH) && (word_i[B_PBANK] == 1'(k));
    end
  endgenerate

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.seq_en   = word_i[B_SEQ];
    ctrl_o.hi_half  = word_i[B_HI];
    ctrl_o.fsel     = word_i[B_FSEL];
    ctrl_o.psel     = word_i[B_PSEL];
    ctrl_o.core_rst = word_i[B_CRST];
    ctrl_o.clk_hold = word_i[B_HOLD];
    ctrl_o.dac_off  = word_i[B_DAC];
    ctrl_o.msb_out  = word_i[B_MSBO];
    ctrl_o.msb_div  = word_i[B_MSBD];
    ctrl_o.tri_sel  = word_i[B_TRI];
  end

  assign unused_bits = ^{word_i[9], word_i[4], word_i[2], word_i[0]};
endmodule

// File: rtl/dds_cw_seq.sv
module dds_cw_seq
  import dds_cw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_en_i,
  input  logic              ctrl_we_i,
  input  logic [NBANK-1:0]  freq_we_i,
  input  logic [HALF_W-1:0] hdata_i,
  output logic              pend_o,
  output logic [HALF_W-1:0] lo_o,
  output logic [NBANK-1:0]  commit_o
);
  logic pend_q, bank_q;
  logic [HALF_W-1:0] lo_q;
  logic any_we, idx;

  assign any_we = |freq_we_i;
  assign idx    = freq_we_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      bank_q <= 1'b0;
      lo_q   <= '0;
    end else if (ctrl_we_i) begin
      pend_q <= 1'b0;
    end else if (any_we && seq_en_i) begin
      if (pend_q && bank_q == idx) begin
        pend_q <= 1'b0;
      end else begin
        // first half, or a different target restarts the pair
        pend_q <= 1'b1;
        bank_q <= idx;
        lo_q   <= hdata_i;
      end
    end
  end

  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_commit
      assign commit_o[k] = freq_we_i[k] && seq_en_i && pend_q && (bank_q == 1'(k));
    end
  endgenerate

  assign pend_o = pend_q;
  assign lo_o   = lo_q;

  // R5
  pair_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_o) && !ctrl_we_i |=> !pend_o);
  // R6
  ctrl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !pend_o);
  // R10
  idle_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_we && !ctrl_we_i |=> $stable(pend_o) && $stable(lo_o));
endmodule

// File: rtl/dds_cw_freq_reg.sv
module dds_cw_freq_reg
  import dds_cw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_we_i,
  input  logic              hi_sel_i,
  input  logic              commit_i,
  input  logic [HALF_W-1:0] lo_i,
  input  logic [HALF_W-1:0] hdata_i,
  output logic [FREQ_W-1:0] val_o
);
  logic [FREQ_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          val_q <= '0;
    else if (commit_i)    val_q <= {hdata_i, lo_i};
    else if (half_we_i) begin
      if (hi_sel_i) val_q[FREQ_W-1:HALF_W] <= hdata_i;
      else          val_q[HALF_W-1:0]      <= hdata_i;
    end
  end

  assign val_o = val_q;

  // R4
  keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_we_i && !hi_sel_i && !commit_i |=> $stable(val_o[FREQ_W-1:HALF_W]));
  // R4
  keep_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_we_i && hi_sel_i && !commit_i |=> $stable(val_o[HALF_W-1:0]));
  // R5
  pair_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> val_o == {$past(hdata_i), $past(lo_i)});
endmodule

// File: rtl/dds_cw_phase_reg.sv
module dds_cw_phase_reg
  import dds_cw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PHASE_W-1:0] data_i,
  output logic [PHASE_W-1:0] val_o
);
  logic [PHASE_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (we_i) val_q <= data_i;
  end

  assign val_o = val_q;

  // R3
  phase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> val_o == $past(data_i));
endmodule

// File: rtl/dds_cw_regfile.sv
module dds_cw_regfile
  import dds_cw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               seq_en_o,
  output logic               hi_half_o,
  output logic               freq_sel_o,
  output logic               phase_sel_o,
  output logic               core_rst_o,
  output logic               clk_hold_o,
  output logic               dac_off_o,
  output logic               msb_out_o,
  output logic               msb_div_o,
  output logic               tri_mode_o,
  output logic               hi_pending_o
);
  ctrl_t              ctrl_d, ctrl_q;
  logic               ctrl_we;
  logic [NBANK-1:0]   freq_we, ph_we, commit;
  logic [HALF_W-1:0]  hdata, lo_held;
  logic [PHASE_W-1:0] pdata;
  logic [FREQ_W-1:0]  freq_q [NBANK];
  logic [PHASE_W-1:0] phase_q [NBANK];

  dds_cw_decode u_dec (
    .wr_i, .word_i,
    .ctrl_we_o(ctrl_we), .ctrl_o(ctrl_d), .freq_we_o(freq_we),
    .ph_we_o(ph_we), .hdata_o(hdata), .pdata_o(pdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  dds_cw_seq u_seq (
    .clk_i, .rst_ni, .seq_en_i(ctrl_q.seq_en), .ctrl_we_i(ctrl_we),
    .freq_we_i(freq_we), .hdata_i(hdata), .pend_o(hi_pending_o),
    .lo_o(lo_held), .commit_o(commit)
  );

  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
      dds_cw_freq_reg u_freq (
        .clk_i, .rst_ni,
        .half_we_i(freq_we[k] && !ctrl_q.seq_en), .hi_sel_i(ctrl_q.hi_half),
        .commit_i(commit[k]), .lo_i(lo_held), .hdata_i(hdata),
        .val_o(freq_q[k])
      );
      dds_cw_phase_reg u_phase (
        .clk_i, .rst_ni, .we_i(ph_we[k]), .data_i(pdata), .val_o(phase_q[k])
      );
    end
  endgenerate

  assign freq0_o  = freq_q[0];
  assign freq1_o  = freq_q[1];
  assign phase0_o = phase_q[0];
  assign phase1_o = phase_q[1];
  assign freq_o   = ctrl_q.fsel ? freq_q[1] : freq_q[0];
  assign phase_o  = ctrl_q.psel ? phase_q[1] : phase_q[0];

  assign seq_en_o    = ctrl_q.seq_en;
  assign hi_half_o   = ctrl_q.hi_half;
  assign freq_sel_o  = ctrl_q.fsel;
  assign phase_sel_o = ctrl_q.psel;
  assign core_rst_o  = ctrl_q.core_rst;
  assign clk_hold_o  = ctrl_q.clk_hold;
  assign dac_off_o   = ctrl_q.dac_off;
  assign msb_out_o   = ctrl_q.msb_out;
  assign msb_div_o   = ctrl_q.msb_div;
  assign tri_mode_o  = ctrl_q.tri_sel;

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(freq0_o) && $stable(freq1_o) && $stable(phase0_o)
              && $stable(phase1_o) && $stable(ctrl_q));
  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && word_i[15:14] == 2'b00 |=> freq_sel_o == $past(word_i[B_FSEL])
                                     && seq_en_o == $past(word_i[B_SEQ]));
  // R5
  first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && seq_en_o && !hi_pending_o && (word_i[15:14] == 2'b01 || word_i[15:14] == 2'b10)
    |=> $stable(freq0_o) && $stable(freq1_o) && hi_pending_o);
  // R8
  sel_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_sel_o |-> freq_o == freq1_o);
endmodule

// File: tb/dds_cw_regfile_test.sv
module dds_cw_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] word = '0;
  logic [27:0] f0, f1, fa;
  logic [11:0] p0, p1, pa;
  logic seq_en, hi_half, fsel, psel, crst, hold, dac, msbo, msbd, tri_m, pend;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dds_cw_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .word_i(word),
    .freq0_o(f0), .freq1_o(f1), .phase0_o(p0), .phase1_o(p1),
    .freq_o(fa), .phase_o(pa), .seq_en_o(seq_en), .hi_half_o(hi_half),
    .freq_sel_o(fsel), .phase_sel_o(psel), .core_rst_o(crst),
    .clk_hold_o(hold), .dac_off_o(dac), .msb_out_o(msbo), .msb_div_o(msbd),
    .tri_mode_o(tri_m), .hi_pending_o(pend)
  );

  // {word, expected freq0, expected freq1, expected pending}
  localparam int NV = 14;
  localparam logic [72:0] VEC [NV] = '{
    {16'h5234, 28'h0001234, 28'h0000000, 1'b0}, // R4 low half, tuning 0
    {16'hBFFF, 28'h0001234, 28'h0003FFF, 1'b0}, // R4 low half, tuning 1
    {16'h1000, 28'h0001234, 28'h0003FFF, 1'b0}, // R2 select high half
    {16'h4ABC, 28'h2AF1234, 28'h0003FFF, 1'b0}, // R4 high half kept low
    {16'h2000, 28'h2AF1234, 28'h0003FFF, 1'b0}, // R2 paired mode
    {16'h8111, 28'h2AF1234, 28'h0003FFF, 1'b1}, // R5 first half
    {16'h8222, 28'h2AF1234, 28'h0888111, 1'b0}, // R5 pair done
    {16'h4005, 28'h2AF1234, 28'h0888111, 1'b1}, // R5
    {16'h8007, 28'h2AF1234, 28'h0888111, 1'b1}, // R7 other target restarts
    {16'h8001, 28'h2AF1234, 28'h0004007, 1'b0}, // R7 new pair closes
    {16'h4003, 28'h2AF1234, 28'h0004007, 1'b1}, // R6 open
    {16'h2000, 28'h2AF1234, 28'h0004007, 1'b0}, // R6 ctrl clears
    {16'h7FFF, 28'h2AF1234, 28'h0004007, 1'b1}, // R6 low again
    {16'h7FFF, 28'hFFFFFFF, 28'h0004007, 1'b0}  // R6 pair done
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    word = w;
    wr   = 1'b1;
    @(negedge clk);
    wr   = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 freq0", 32'(f0), 0);
    chk("R1 freq1", 32'(f1), 0);
    chk("R1 phase", 32'({p0, p1}), 0);
    chk("R1 flags", 32'({seq_en, hi_half, fsel, psel, crst, hold, dac, msbo, msbd, tri_m, pend}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      put(VEC[i][72:57]);
      chk("R4/R5/R6/R7 freq0", 32'(f0), 32'(VEC[i][56:29]));
      chk("R4/R5/R6/R7 freq1", 32'(f1), 32'(VEC[i][28:1]));
      chk("R5/R6/R7 pending", 32'(pend), 32'(VEC[i][0]));
    end

    // R2 all flags set, R8 selection
    put(16'h0DEA);
    chk("R2 flags", 32'({seq_en, hi_half, fsel, psel, crst, hold, dac, msbo, msbd, tri_m}),
        32'b0011111111);
    chk("R8 freq select 1", 32'(fa), 32'h0004007);
    put(16'h0000);
    chk("R2 flags clear", 32'({fsel, psel, crst, hold, dac, msbo, msbd, tri_m}), 0);
    chk("R8 freq select 0", 32'(fa), 32'hFFFFFFF);

    // R3 phase writes
    put(16'hCABC);
    chk("R3 phase0", 32'(p0), 32'hABC);
    put(16'hE123);
    chk("R3 phase1", 32'(p1), 32'h123);
    chk("R3 phase0 kept", 32'(p0), 32'hABC);
    put(16'hF456);
    chk("R3 bit12 ignored", 32'(p1), 32'h456);
    chk("R8 phase select 0", 32'(pa), 32'hABC);
    put(16'h0400);
    chk("R8 phase select 1", 32'(pa), 32'h456);

    // R10 phase write inside a pair
    put(16'h2000);
    put(16'h4010);
    put(16'hC777);
    chk("R10 pending kept", 32'(pend), 1);
    chk("R3 phase0 in pair", 32'(p0), 32'h777);
    put(16'h4020);
    chk("R10 held low half", 32'(f0), 32'h0080010);

    // R9 no strobe
    @(negedge clk);
    word = 16'h0FFF;
    repeat (3) @(negedge clk);
    word = 16'h5555;
    @(negedge clk);
    chk("R9 ctrl", 32'({seq_en, fsel, crst}), 32'b100);
    chk("R9 freq0", 32'(f0), 32'h0080010);
    chk("R9 pending", 32'(pend), 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async freq0", 32'(f0), 0);
    chk("R1 async phase1", 32'(p1), 0);
    chk("R1 async seq", 32'(seq_en), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule